// File: doc/BRIEF.md
# Debug Interrupt Breakpoint Controller

This block sits in the sequencer of a processor core and handles its single debug interrupt. Software arms a breakpoint with a set command. The breakpoint is either a single step, which fires on the next retired instruction, or an address match, which fires when an instruction at a chosen PC retires. When the breakpoint fires, the block packs the return PC and the carry and zero flags into a hidden save register. It then redirects the core to the address held in a hidden vector register. Taking the interrupt disarms the breakpoint. A debug routine that wants another stop must therefore arm it again before it leaves.

While the debug routine runs, two ordinary register addresses are served from the block instead of from the register file. One of them returns the vector and the other returns the save word. The routine leaves debug mode with exactly one instruction form: an indirect call through the save register that restores both flags. That call may store its own return address into the vector register. When it does, the next debug interrupt resumes the routine at that point instead of at its start. At reset, the vector depends on the core number. A routine can therefore tell a restart from a resume by where it was entered.

Top module: `dbg_brk_ctrl`

## Requirements
- R1: After reset, `dbg_active` and `redir_valid` are low, and the vector register holds 0xFFFC0 + 4*`core_id`, with `core_id` sampled during reset.
- R2: A set command with `brk_mode`=1 (single step) arms a step breakpoint from the next cycle. The next retired instruction (`ex_valid`) outside debug mode then triggers entry. One cycle later, `redir_valid` pulses with `redir_pc` equal to the vector, `redir_c`/`redir_z` equal to that instruction's flags, and `dbg_active` high.
- R3: With `brk_mode`=2 (address match), entry triggers only when a retired instruction has `ex_pc` equal to the stored `brk_addr`. Other PCs do not trigger entry. `brk_mode` values 0 and 3 disarm the breakpoint.
- R4: On entry, the save register holds C in bit 31, Z in bit 30 and the return address `ex_next_pc` in bits 19:0, all loaded in the entry cycle.
- R5: Every entry disarms the breakpoint. A set command issued in the entry cycle is lost, so after exit no further entry occurs until the breakpoint is armed again.
- R6: While `dbg_active` is high, no breakpoint causes entry. An arming made during the routine stays pending until after exit.
- R7: Exit happens only on a retired instruction in debug mode with `ex_calli`=1, `ex_src`=SAVE_REG (0x1FF), `ex_wc`=1 and `ex_wz`=1. One cycle later, `redir_valid` pulses with PC, C and Z taken from the save register, and `dbg_active` is low. Missing either flag write, or a different source register, is not an exit.
- R8: A register write in debug mode to VEC_REG (0x1FE), including the write made by the exit call, replaces the vector. The next entry then redirects to the new value.
- R9: Only while `dbg_active` is high, a read of VEC_REG or SAVE_REG raises `rd_hit` and returns the vector (zero-extended) or the save word. Outside debug mode, `rd_hit` is low, and writes to those addresses leave the shadow contents unchanged.
- R10: `dbg_active` rises in the cycle after the triggering instruction retires, stays high through the routine, and falls in the cycle after the exit instruction retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset (core restart) |
| core_id | input | 3 | Core number, selects the reset vector |
| ex_valid | input | 1 | An instruction retires this cycle |
| ex_pc | input | 20 | PC of the retiring instruction |
| ex_next_pc | input | 20 | Address execution would continue at |
| ex_c | input | 1 | Carry flag after the instruction |
| ex_z | input | 1 | Zero flag after the instruction |
| ex_calli | input | 1 | Instruction is an indirect call |
| ex_src | input | 9 | Register the indirect call jumps through |
| ex_wc | input | 1 | Instruction writes carry |
| ex_wz | input | 1 | Instruction writes zero |
| ex_wr_en | input | 1 | Instruction writes a register |
| ex_dst | input | 9 | Destination register address |
| ex_wr_data | input | 32 | Data written to the destination |
| brk_set | input | 1 | Set-breakpoint command |
| brk_mode | input | 2 | 0 off, 1 single step, 2 address match, 3 off |
| brk_addr | input | 20 | Match address for mode 2 |
| rd_addr | input | 9 | Register read address to test for overlay |
| rd_hit | output | 1 | Read is served by shadow storage |
| rd_data | output | 32 | Shadow read data |
| redir_valid | output | 1 | One-cycle redirect request |
| redir_pc | output | 20 | Redirect target |
| redir_c | output | 1 | Carry to load with the redirect |
| redir_z | output | 1 | Zero to load with the redirect |
| dbg_active | output | 1 | Debug routine in progress |

## Verification
The main function is driven with a step breakpoint, an address breakpoint presented both at a non-matching PC and at the matching PC, and near-miss exit forms. The near misses are an indirect call without the zero write and one through an ordinary register. Together these tell a real trigger from a masked or absent one, and the one exit form from its look-alikes. A set command coinciding with entry shows whether the automatic disarm takes priority. An exit that rewrites the vector, compared with one that does not, separates a resumed routine from one restarted at its base. Resetting under a second core number shows that the reset vector follows the core number.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;
  typedef enum logic [1:0] {
    BRK_OFF  = 2'd0,
    BRK_STEP = 2'd1,
    BRK_ADDR = 2'd2,
    BRK_RSVD = 2'd3
  } brk_mode_e;
endpackage

// File: rtl/dbg_trigger.sv
module dbg_trigger
  import dbg_brk_pkg::*;
#(
  parameter int PC_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_i,
  input  logic [1:0]      mode_i,
  input  logic [PC_W-1:0] addr_i,
  input  logic            ex_valid_i,
  input  logic [PC_W-1:0] ex_pc_i,
  input  logic            dbg_active_i,
  output logic            entry_o,
  output logic            armed_o
);
  brk_mode_e       mode_q;
  logic [PC_W-1:0] addr_q;

  function automatic logic bp_hit(input brk_mode_e m, input logic [PC_W-1:0] a,
                                  input logic [PC_W-1:0] pc);
    case (m)
      BRK_STEP: bp_hit = 1'b1;
      BRK_ADDR: bp_hit = (pc == a);
      default:  bp_hit = 1'b0;
    endcase
  endfunction

  assign entry_o = ex_valid_i && !dbg_active_i && bp_hit(mode_q, addr_q, ex_pc_i);
  assign armed_o = (mode_q == BRK_STEP) || (mode_q == BRK_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= BRK_OFF;
      addr_q <= '0;
    end else if (entry_o) begin
      mode_q <= BRK_OFF;
    end else if (set_i) begin
      mode_q <= brk_mode_e'(mode_i);
      addr_q <= addr_i;
    end
  end

  // R5
  property disarm_on_entry_p;
    @(posedge clk) disable iff (!rst_n) entry_o |=> !armed_o;
  endproperty
  disarm_on_entry_chk: assert property (disarm_on_entry_p);

  // R6
  property masked_in_debug_p;
    @(posedge clk) disable iff (!rst_n) (dbg_active_i && armed_o) |=> armed_o;
  endproperty
  masked_in_debug_chk: assert property (masked_in_debug_p);
endmodule

// File: rtl/dbg_shadow.sv
module dbg_shadow #(
  parameter int              PC_W     = 20,
  parameter int              DATA_W   = 32,
  parameter int              ADDR_W   = 9,
  parameter int              ID_W     = 3,
  parameter logic [PC_W-1:0] VEC_BASE = 20'hFFFC0,
  parameter logic [ADDR_W-1:0] VEC_REG  = 9'h1FE,
  parameter logic [ADDR_W-1:0] SAVE_REG = 9'h1FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   core_id_i,
  input  logic              entry_i,
  input  logic [PC_W-1:0]   ret_pc_i,
  input  logic              c_i,
  input  logic              z_i,
  input  logic              dbg_active_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [PC_W-1:0]   vec_o,
  output logic [DATA_W-1:0] save_o,
  output logic              rd_hit_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int C_BIT = DATA_W - 1;
  localparam int Z_BIT = DATA_W - 2;
  localparam int PAD_W = DATA_W - PC_W;

  logic [PC_W-1:0]   vec_q;
  logic [DATA_W-1:0] save_q;
  logic              wr_vec, wr_save;

  function automatic logic [PC_W-1:0] reset_vector(input logic [ID_W-1:0] id);
    reset_vector = VEC_BASE + (PC_W'(id) << 2);
  endfunction

  function automatic logic [DATA_W-1:0] pack_save(input logic c, input logic z,
                                                  input logic [PC_W-1:0] pc);
    logic [DATA_W-1:0] w;
    w        = {{PAD_W{1'b0}}, pc};
    w[C_BIT] = c;
    w[Z_BIT] = z;
    pack_save = w;
  endfunction

  assign wr_vec  = dbg_active_i && wr_en_i && (wr_addr_i == VEC_REG);
  assign wr_save = dbg_active_i && wr_en_i && (wr_addr_i == SAVE_REG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q  <= reset_vector(core_id_i);
      save_q <= '0;
    end else begin
      if (entry_i)      save_q <= pack_save(c_i, z_i, ret_pc_i);
      else if (wr_save) save_q <= wr_data_i;
      if (wr_vec)       vec_q  <= wr_data_i[PC_W-1:0];
    end
  end

  always_comb begin
    rd_hit_o  = 1'b0;
    rd_data_o = '0;
    if (dbg_active_i) begin
      if (rd_addr_i == VEC_REG) begin
        rd_hit_o  = 1'b1;
        rd_data_o = {{PAD_W{1'b0}}, vec_q};
      end else if (rd_addr_i == SAVE_REG) begin
        rd_hit_o  = 1'b1;
        rd_data_o = save_q;
      end
    end
  end

  assign vec_o  = vec_q;
  assign save_o = save_q;

  // R4
  property save_pack_p;
    @(posedge clk) disable iff (!rst_n)
      entry_i |=> (save_q[C_BIT] == $past(c_i)) && (save_q[Z_BIT] == $past(z_i))
                  && (save_q[PC_W-1:0] == $past(ret_pc_i));
  endproperty
  save_pack_chk: assert property (save_pack_p);

  // R9
  property vec_frozen_p;
    @(posedge clk) disable iff (!rst_n) !dbg_active_i |=> $stable(vec_q);
  endproperty
  vec_frozen_chk: assert property (vec_frozen_p);
endmodule

// File: rtl/dbg_seq.sv
module dbg_seq #(
  parameter int              PC_W     = 20,
  parameter int              DATA_W   = 32,
  parameter int              ADDR_W   = 9,
  parameter logic [ADDR_W-1:0] SAVE_REG = 9'h1FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_i,
  input  logic              ex_valid_i,
  input  logic              ex_calli_i,
  input  logic [ADDR_W-1:0] ex_src_i,
  input  logic              ex_wc_i,
  input  logic              ex_wz_i,
  input  logic              ex_c_i,
  input  logic              ex_z_i,
  input  logic [PC_W-1:0]   vec_i,
  input  logic [DATA_W-1:0] save_i,
  output logic              dbg_active_o,
  output logic              exit_o,
  output logic              redir_valid_o,
  output logic [PC_W-1:0]   redir_pc_o,
  output logic              redir_c_o,
  output logic              redir_z_o
);
  logic            active_q, rv_q, rc_q, rz_q;
  logic [PC_W-1:0] rpc_q;

  function automatic logic is_exit(input logic calli, input logic [ADDR_W-1:0] src,
                                   input logic wc, input logic wz);
    is_exit = calli && (src == SAVE_REG) && wc && wz;
  endfunction

  assign exit_o = ex_valid_i && active_q && is_exit(ex_calli_i, ex_src_i, ex_wc_i, ex_wz_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rv_q     <= 1'b0;
      rpc_q    <= '0;
      rc_q     <= 1'b0;
      rz_q     <= 1'b0;
    end else begin
      rv_q <= 1'b0;
      if (entry_i) begin
        active_q <= 1'b1;
        rv_q     <= 1'b1;
        rpc_q    <= vec_i;
        rc_q     <= ex_c_i;
        rz_q     <= ex_z_i;
      end else if (exit_o) begin
        active_q <= 1'b0;
        rv_q     <= 1'b1;
        rpc_q    <= save_i[PC_W-1:0];
        rc_q     <= save_i[DATA_W-1];
        rz_q     <= save_i[DATA_W-2];
      end
    end
  end

  assign dbg_active_o  = active_q;
  assign redir_valid_o = rv_q;
  assign redir_pc_o    = rpc_q;
  assign redir_c_o     = rc_q;
  assign redir_z_o     = rz_q;

  // R2
  property entry_redir_p;
    @(posedge clk) disable iff (!rst_n) entry_i |=> (active_q && rv_q);
  endproperty
  entry_redir_chk: assert property (entry_redir_p);

  // R7
  property exit_redir_p;
    @(posedge clk) disable iff (!rst_n)
      exit_o |=> (!active_q && rv_q && (rpc_q == $past(save_i[PC_W-1:0])));
  endproperty
  exit_redir_chk: assert property (exit_redir_p);

  // R10
  property active_rise_p;
    @(posedge clk) disable iff (!rst_n) $rose(active_q) |-> rv_q;
  endproperty
  active_rise_chk: assert property (active_rise_p);
endmodule

// File: rtl/dbg_brk_ctrl.sv
module dbg_brk_ctrl #(
  parameter int              PC_W     = 20,
  parameter int              DATA_W   = 32,
  parameter int              ADDR_W   = 9,
  parameter int              ID_W     = 3,
  parameter logic [PC_W-1:0] VEC_BASE = 20'hFFFC0,
  parameter logic [ADDR_W-1:0] VEC_REG  = 9'h1FE,
  parameter logic [ADDR_W-1:0] SAVE_REG = 9'h1FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   core_id,
  input  logic              ex_valid,
  input  logic [PC_W-1:0]   ex_pc,
  input  logic [PC_W-1:0]   ex_next_pc,
  input  logic              ex_c,
  input  logic              ex_z,
  input  logic              ex_calli,
  input  logic [ADDR_W-1:0] ex_src,
  input  logic              ex_wc,
  input  logic              ex_wz,
  input  logic              ex_wr_en,
  input  logic [ADDR_W-1:0] ex_dst,
  input  logic [DATA_W-1:0] ex_wr_data,
  input  logic              brk_set,
  input  logic [1:0]        brk_mode,
  input  logic [PC_W-1:0]   brk_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data,
  output logic              redir_valid,
  output logic [PC_W-1:0]   redir_pc,
  output logic              redir_c,
  output logic              redir_z,
  output logic              dbg_active
);
  logic              entry_ev, exit_ev, armed;
  logic [PC_W-1:0]   vec_w;
  logic [DATA_W-1:0] save_w;

  dbg_trigger #(.PC_W(PC_W)) u_trig (
    .clk, .rst_n,
    .set_i(brk_set), .mode_i(brk_mode), .addr_i(brk_addr),
    .ex_valid_i(ex_valid), .ex_pc_i(ex_pc), .dbg_active_i(dbg_active),
    .entry_o(entry_ev), .armed_o(armed)
  );

  dbg_shadow #(
    .PC_W(PC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W),
    .VEC_BASE(VEC_BASE), .VEC_REG(VEC_REG), .SAVE_REG(SAVE_REG)
  ) u_shadow (
    .clk, .rst_n, .core_id_i(core_id),
    .entry_i(entry_ev), .ret_pc_i(ex_next_pc), .c_i(ex_c), .z_i(ex_z),
    .dbg_active_i(dbg_active),
    .wr_en_i(ex_valid && ex_wr_en), .wr_addr_i(ex_dst), .wr_data_i(ex_wr_data),
    .rd_addr_i(rd_addr), .vec_o(vec_w), .save_o(save_w),
    .rd_hit_o(rd_hit), .rd_data_o(rd_data)
  );

  dbg_seq #(
    .PC_W(PC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SAVE_REG(SAVE_REG)
  ) u_seq (
    .clk, .rst_n, .entry_i(entry_ev),
    .ex_valid_i(ex_valid), .ex_calli_i(ex_calli), .ex_src_i(ex_src),
    .ex_wc_i(ex_wc), .ex_wz_i(ex_wz), .ex_c_i(ex_c), .ex_z_i(ex_z),
    .vec_i(vec_w), .save_i(save_w),
    .dbg_active_o(dbg_active), .exit_o(exit_ev),
    .redir_valid_o(redir_valid), .redir_pc_o(redir_pc),
    .redir_c_o(redir_c), .redir_z_o(redir_z)
  );

  // R6
  property no_reentry_p;
    @(posedge clk) disable iff (!rst_n) (dbg_active && !exit_ev) |=> !$rose(redir_valid) || dbg_active;
  endproperty
  no_reentry_chk: assert property (no_reentry_p);

  // R5
  property armed_cleared_p;
    @(posedge clk) disable iff (!rst_n) $rose(dbg_active) |-> !armed;
  endproperty
  armed_cleared_chk: assert property (armed_cleared_p);
endmodule

// File: tb/sim_dbg_brk_ctrl.sv
module sim_dbg_brk_ctrl;
  typedef struct packed {
    logic v; logic [19:0] pc; logic [19:0] npc; logic c; logic z; logic calli;
    logic [8:0] src; logic wc; logic wz; logic wen; logic [8:0] dst; logic [31:0] wd;
    logic set; logic [1:0] mode; logic [19:0] baddr;
    logic e_act; logic e_rv; logic [19:0] e_rpc; logic e_rc; logic e_rz;
  } vec_t;

  localparam logic [8:0] S = 9'h1FF, V = 9'h1FE, N = 9'h1F0;

  localparam vec_t TBL [12] = '{
    '{0,20'h0,20'h0,0,0,0,N,0,0,0,N,32'h0,1,2'd1,20'h0, 0,0,20'h0,0,0},
    '{1,20'h00100,20'h00101,1,0,0,N,0,0,0,N,32'h0,0,2'd0,20'h0, 1,1,20'hFFFCC,1,0},
    '{1,20'hFFFCC,20'hFFFCD,0,0,0,N,0,0,0,N,32'h0,0,2'd0,20'h0, 1,0,20'h0,0,0},
    '{1,20'hFFFCD,20'hFFFCE,0,0,0,N,0,0,0,N,32'h0,1,2'd2,20'h00200, 1,0,20'h0,0,0},
    '{1,20'h00200,20'h00201,0,0,0,N,0,0,0,N,32'h0,0,2'd0,20'h0, 1,0,20'h0,0,0},
    '{1,20'hFFFCE,20'h00101,0,0,1,S,1,1,1,V,32'hFFFCF,0,2'd0,20'h0, 0,1,20'h00101,1,0},
    '{1,20'h00101,20'h00102,0,0,0,N,0,0,0,N,32'h0,0,2'd0,20'h0, 0,0,20'h0,0,0},
    '{1,20'h00200,20'h00201,0,1,0,N,0,0,0,N,32'h0,0,2'd0,20'h0, 1,1,20'hFFFCF,0,1},
    '{1,20'hFFFCF,20'hFFFD0,0,0,1,S,1,0,0,N,32'h0,0,2'd0,20'h0, 1,0,20'h0,0,0},
    '{1,20'hFFFD0,20'hFFFD1,0,0,1,N,1,1,0,N,32'h0,0,2'd0,20'h0, 1,0,20'h0,0,0},
    '{1,20'hFFFD1,20'h00201,0,0,1,S,1,1,1,N,32'hFFFD2,0,2'd0,20'h0, 0,1,20'h00201,0,1},
    '{1,20'h00200,20'h00201,0,0,0,N,0,0,0,N,32'h0,0,2'd0,20'h0, 0,0,20'h0,0,0}
  };
  localparam string TAGS [12] = '{"R2","R2","R10","R6","R6","R7","R3","R8","R7","R7","R7","R5"};

  logic clk = 0, rst_n = 0;
  logic [2:0] core_id = 3'd3;
  logic ex_valid = 0, ex_c = 0, ex_z = 0, ex_calli = 0, ex_wc = 0, ex_wz = 0, ex_wr_en = 0;
  logic [19:0] ex_pc = 0, ex_next_pc = 0, brk_addr = 0;
  logic [8:0] ex_src = N, ex_dst = N, rd_addr = N;
  logic [31:0] ex_wr_data = 0;
  logic brk_set = 0;
  logic [1:0] brk_mode = 0;
  logic rd_hit, redir_valid, redir_c, redir_z, dbg_active;
  logic [31:0] rd_data;
  logic [19:0] redir_pc;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbg_brk_ctrl u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input vec_t r, input string tag);
    ex_valid = r.v; ex_pc = r.pc; ex_next_pc = r.npc; ex_c = r.c; ex_z = r.z;
    ex_calli = r.calli; ex_src = r.src; ex_wc = r.wc; ex_wz = r.wz;
    ex_wr_en = r.wen; ex_dst = r.dst; ex_wr_data = r.wd;
    brk_set = r.set; brk_mode = r.mode; brk_addr = r.baddr;
    @(negedge clk);
    ex_valid = 0; brk_set = 0; ex_wr_en = 0; ex_calli = 0;
    chk({tag, " dbg_active"}, 32'(dbg_active), 32'(r.e_act));
    chk({tag, " redir_valid"}, 32'(redir_valid), 32'(r.e_rv));
    if (r.e_rv) begin
      chk({tag, " redir_pc"}, 32'(redir_pc), 32'(r.e_rpc));
      chk({tag, " redir_flags"}, 32'({redir_c, redir_z}), 32'({r.e_rc, r.e_rz}));
    end
  endtask

  task automatic idle_row(output vec_t r);
    r = '{0,20'h0,20'h0,0,0,0,N,0,0,0,N,32'h0,0,2'd0,20'h0, 0,0,20'h0,0,0};
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 dbg_active", 32'(dbg_active), 0);
    chk("R1 redir_valid", 32'(redir_valid), 0);
    rd_addr = V; #1;
    chk("R9 rd_hit idle", 32'(rd_hit), 0);

    for (int i = 0; i < 12; i++) run(TBL[i], TAGS[i]);

    // R9: write to vector address outside debug mode is ignored
    idle_row(r); r.v = 1; r.pc = 20'h00400; r.npc = 20'h00401; r.wen = 1; r.dst = V; r.wd = 32'h12345;
    run(r, "R9");
    rd_addr = V; #1;
    chk("R9 rd_hit normal", 32'(rd_hit), 0);

    idle_row(r); r.set = 1; r.mode = 2'd1;
    run(r, "R2");
    // R5: set in entry cycle is lost; R8 vector unchanged by ignored write
    idle_row(r); r.v = 1; r.pc = 20'h00300; r.npc = 20'h00301; r.c = 1; r.z = 1;
    r.set = 1; r.mode = 2'd1; r.e_act = 1; r.e_rv = 1; r.e_rpc = 20'hFFFCF; r.e_rc = 1; r.e_rz = 1;
    run(r, "R8");
    rd_addr = S; #1;
    chk("R9 rd_hit save", 32'(rd_hit), 1);
    chk("R4 save word", rd_data, 32'hC0000301);
    rd_addr = V; #1;
    chk("R9 vector read", rd_data, 32'h000FFFCF);

    idle_row(r); r.v = 1; r.pc = 20'hFFFCF; r.npc = 20'h00301; r.calli = 1; r.src = S; r.wc = 1; r.wz = 1;
    r.e_rv = 1; r.e_rpc = 20'h00301; r.e_rc = 1; r.e_rz = 1;
    run(r, "R7");
    idle_row(r); r.v = 1; r.pc = 20'h00301; r.npc = 20'h00302;
    run(r, "R5");

    // R1: restart with another core number
    rst_n = 0; core_id = 3'd0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 dbg_active after restart", 32'(dbg_active), 0);
    idle_row(r); r.set = 1; r.mode = 2'd1;
    run(r, "R2");
    idle_row(r); r.v = 1; r.pc = 20'h00010; r.npc = 20'h00011;
    r.e_act = 1; r.e_rv = 1; r.e_rpc = 20'hFFFC0;
    run(r, "R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule